// File: doc/BRIEF.md
# Multi-Port CPU Register File

This block is the general-purpose register storage of an 8-bit microcontroller core. It holds 32 byte-wide registers. Two read ports work independently and combinationally, each selecting one register by its own address. One write port stores a byte into an addressed register on the rising clock edge.

The top six registers also form three 16-bit pointer pairs, called X, Y and Z. Each pair has its own write port, with an enable and a 16-bit data word, and the register file drives each pair out continuously for address generation. All six ports may be used in the same cycle. When a pointer port and the byte port write the same register, the pointer port's value is stored.

Top module: `regfile_mp`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero, so both read ports and all three pointer outputs return zero afterwards.
- R2: Read port 1 returns, without a clock, the register selected by its 5-bit address.
- R3: Read port 2 returns its own addressed register independently of read port 1, including when both address the same register or different ones.
- R4: When the byte write is enabled, its data is stored into the addressed register at the rising edge, and no other register changes because of it.
- R5: An X pointer write stores data bits 7:0 into register 26 and bits 15:8 into register 27 at the rising edge.
- R6: A Y pointer write stores bits 7:0 into register 28 and bits 15:8 into register 29.
- R7: A Z pointer write stores bits 7:0 into register 30 and bits 15:8 into register 31.
- R8: When a pointer write and the byte write target the same register in one cycle, the pointer data is stored; byte writes to registers not covered by an active pointer write in that cycle still take effect.
- R9: A read in the cycle of a write to the same register returns the value stored before that edge; the new value appears only after the edge.
- R10: The X, Y and Z outputs always equal {r27,r26}, {r29,r28} and {r31,r30}, whatever port last changed those registers.
- R11: With every write enable low, data and address on the write ports have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd1_addr | input | 5 | Read port 1 register select |
| rd1_data | output | 8 | Read port 1 data |
| rd2_addr | input | 5 | Read port 2 register select |
| rd2_data | output | 8 | Read port 2 data |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Byte write register select |
| wr_data | input | 8 | Byte write data |
| xw_en | input | 1 | X pair write enable |
| xw_data | input | 16 | X pair write data |
| yw_en | input | 1 | Y pair write enable |
| yw_data | input | 16 | Y pair write data |
| zw_en | input | 1 | Z pair write enable |
| zw_data | input | 16 | Z pair write data |
| x_ptr | output | 16 | Current X pair |
| y_ptr | output | 16 | Current Y pair |
| z_ptr | output | 16 | Current Z pair |

## Verification
The bench aims the byte write at registers 26 to 31 while pointer writes are active, so a design that gave the byte port priority, or that blocked the byte write to a register of the other half of the pair, stores the wrong byte. It reads a register in the same cycle it is written, which exposes a design that forwards new data and so breaks the old-value rule. It swaps the halves it expects from each 16-bit pointer word, catching a design that puts the high byte at the even address. A long random run with all ports active at once catches writes that leak into neighbouring registers or that happen with the enable low.

// File: rtl/regfile_mp.sv
module regfile_mp #(
  parameter int NREGS = 32,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] rd1_addr,
  output logic [DW-1:0]            rd1_data,
  input  logic [$clog2(NREGS)-1:0] rd2_addr,
  output logic [DW-1:0]            rd2_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     xw_en,
  input  logic [2*DW-1:0]          xw_data,
  input  logic                     yw_en,
  input  logic [2*DW-1:0]          yw_data,
  input  logic                     zw_en,
  input  logic [2*DW-1:0]          zw_data,
  output logic [2*DW-1:0]          x_ptr,
  output logic [2*DW-1:0]          y_ptr,
  output logic [2*DW-1:0]          z_ptr
);
  localparam int AW = $clog2(NREGS);
  localparam int XL = NREGS - 6;
  localparam int YL = NREGS - 4;
  localparam int ZL = NREGS - 2;

  logic [NREGS-1:0][DW-1:0] regs;
  logic [NREGS-1:0]         ptr_hit;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DW-1:0] q;
    logic [DW-1:0] pv;

    if (g == XL) begin : g_xl
      assign ptr_hit[g] = xw_en;
      assign pv = xw_data[DW-1:0];
    end else if (g == XL + 1) begin : g_xh
      assign ptr_hit[g] = xw_en;
      assign pv = xw_data[2*DW-1:DW];
    end else if (g == YL) begin : g_yl
      assign ptr_hit[g] = yw_en;
      assign pv = yw_data[DW-1:0];
    end else if (g == YL + 1) begin : g_yh
      assign ptr_hit[g] = yw_en;
      assign pv = yw_data[2*DW-1:DW];
    end else if (g == ZL) begin : g_zl
      assign ptr_hit[g] = zw_en;
      assign pv = zw_data[DW-1:0];
    end else if (g == ZL + 1) begin : g_zh
      assign ptr_hit[g] = zw_en;
      assign pv = zw_data[2*DW-1:DW];
    end else begin : g_gp
      assign ptr_hit[g] = 1'b0;
      assign pv = '0;
    end

    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (ptr_hit[g])
        q <= pv;
      else if (wr_en && wr_addr == AW'(g))
        q <= wr_data;
    end

    assign regs[g] = q;
  end

  assign rd1_data = regs[rd1_addr];
  assign rd2_data = regs[rd2_addr];

  assign x_ptr = {regs[XL+1], regs[XL]};
  assign y_ptr = {regs[YL+1], regs[YL]};
  assign z_ptr = {regs[ZL+1], regs[ZL]};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (x_ptr == '0 && y_ptr == '0 && z_ptr == '0));

  // R4
  byte_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_hit[wr_addr]) |=> regs[$past(wr_addr)] == $past(wr_data));

  // R5
  x_load_chk: assert property (@(posedge clk) disable iff (rst)
    xw_en |=> x_ptr == $past(xw_data));

  // R6
  y_load_chk: assert property (@(posedge clk) disable iff (rst)
    yw_en |=> y_ptr == $past(yw_data));

  // R7
  z_load_chk: assert property (@(posedge clk) disable iff (rst)
    zw_en |=> z_ptr == $past(zw_data));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !xw_en && !yw_en && !zw_en) |=> $stable(regs));
endmodule

// File: tb/test_regfile_mp.sv
module test_regfile_mp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd1_addr = '0, rd2_addr = '0, wr_addr = '0;
  logic [7:0]  rd1_data, rd2_data, wr_data = '0;
  logic        wr_en = 1'b0, xw_en = 1'b0, yw_en = 1'b0, zw_en = 1'b0;
  logic [15:0] xw_data = '0, yw_data = '0, zw_data = '0;
  logic [15:0] x_ptr, y_ptr, z_ptr;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] m [32];

  always #10 clk = ~clk;

  regfile_mp i_regfile_mp (
    .clk(clk), .rst(rst),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .rd2_addr(rd2_addr), .rd2_data(rd2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xw_en(xw_en), .xw_data(xw_data),
    .yw_en(yw_en), .yw_data(yw_data),
    .zw_en(zw_en), .zw_data(zw_data),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pair(int lo);
    return {m[lo+1], m[lo]};
  endfunction

  task automatic compare(string tag);
    chk({tag, " R2 rd1"}, {8'h0, rd1_data}, {8'h0, m[rd1_addr]});
    chk({tag, " R3 rd2"}, {8'h0, rd2_data}, {8'h0, m[rd2_addr]});
    chk({tag, " R10 x"}, x_ptr, pair(26));
    chk({tag, " R10 y"}, y_ptr, pair(28));
    chk({tag, " R10 z"}, z_ptr, pair(30));
  endtask

  task automatic model_update();
    if (rst) begin
      for (int i = 0; i < 32; i++) m[i] = '0;
    end else begin
      if (wr_en) m[wr_addr] = wr_data;
      if (xw_en) begin m[26] = xw_data[7:0]; m[27] = xw_data[15:8]; end
      if (yw_en) begin m[28] = yw_data[7:0]; m[29] = yw_data[15:8]; end
      if (zw_en) begin m[30] = zw_data[7:0]; m[31] = zw_data[15:8]; end
    end
  endtask

  task automatic tick(string tag);
    #1;
    compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; xw_en = 1'b0; yw_en = 1'b0; zw_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 8'hxx;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b1; wr_addr = 5'd3; wr_data = 8'h77;
    @(posedge clk); model_update(); @(negedge clk);
    @(posedge clk); model_update(); @(negedge clk);
    rst = 1'b0;
    idle();

    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i++) begin
      rd1_addr = 5'(i); rd2_addr = 5'(31 - i);
      #1;
      chk("R1 rd1", {8'h0, rd1_data}, 16'h0);
      chk("R1 rd2", {8'h0, rd2_data}, 16'h0);
      #1;
    end
    chk("R1 x", x_ptr, 16'h0);
    chk("R1 y", y_ptr, 16'h0);
    chk("R1 z", z_ptr, 16'h0);

    // R4 and R9: write r5, read it in the same cycle
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 8'hA5;
    rd1_addr = 5'd5; rd2_addr = 5'd4;
    #1;
    chk("R9 old value", {8'h0, rd1_data}, 16'h0000);
    tick("R4");
    idle();
    rd1_addr = 5'd5; rd2_addr = 5'd6;
    #1;
    chk("R4 written", {8'h0, rd1_data}, 16'h00A5);
    chk("R4 neighbour", {8'h0, rd2_data}, 16'h0000);
    rd2_addr = 5'd5;
    #1;
    chk("R3 same addr", {8'h0, rd2_data}, 16'h00A5);

    // R5 R6 R7: pointer loads, byte order
    xw_en = 1'b1; xw_data = 16'h1234;
    yw_en = 1'b1; yw_data = 16'h5678;
    zw_en = 1'b1; zw_data = 16'h9ABC;
    tick("R5R6R7");
    idle();
    rd1_addr = 5'd26; rd2_addr = 5'd27;
    #1;
    chk("R5 low", {8'h0, rd1_data}, 16'h0034);
    chk("R5 high", {8'h0, rd2_data}, 16'h0012);
    rd1_addr = 5'd28; rd2_addr = 5'd29;
    #1;
    chk("R6 low", {8'h0, rd1_data}, 16'h0078);
    chk("R6 high", {8'h0, rd2_data}, 16'h0056);
    rd1_addr = 5'd30; rd2_addr = 5'd31;
    #1;
    chk("R7 low", {8'h0, rd1_data}, 16'h00BC);
    chk("R7 high", {8'h0, rd2_data}, 16'h009A);
    chk("R10 x", x_ptr, 16'h1234);
    chk("R10 z", z_ptr, 16'h9ABC);

    // R8: collision on r27, then byte write to a pair whose port is idle
    xw_en = 1'b1; xw_data = 16'hBEEF;
    wr_en = 1'b1; wr_addr = 5'd27; wr_data = 8'h11;
    tick("R8a");
    idle();
    #1;
    chk("R8 pointer wins", x_ptr, 16'hBEEF);
    zw_en = 1'b1; zw_data = 16'hCAFE;
    wr_en = 1'b1; wr_addr = 5'd28; wr_data = 8'h3D;
    tick("R8b");
    idle();
    #1;
    chk("R8 other byte write lands", y_ptr, 16'h563D);
    chk("R8 z", z_ptr, 16'hCAFE);

    // R11: garbage on write buses with enables low
    wr_addr = 5'd5; wr_data = 8'hFF;
    xw_data = 16'hFFFF; yw_data = 16'hFFFF; zw_data = 16'hFFFF;
    tick("R11");
    rd1_addr = 5'd5;
    #1;
    chk("R11 r5 kept", {8'h0, rd1_data}, 16'h00A5);
    chk("R11 x kept", x_ptr, 16'hBEEF);

    // random traffic, biased toward pointer registers
    for (int n = 0; n < 3000; n++) begin
      wr_en   = 1'($urandom_range(1));
      wr_addr = ($urandom_range(1) == 1) ? 5'(26 + $urandom_range(5)) : 5'($urandom_range(31));
      wr_data = 8'($urandom());
      xw_en   = ($urandom_range(3) == 0);
      yw_en   = ($urandom_range(3) == 0);
      zw_en   = ($urandom_range(3) == 0);
      xw_data = 16'($urandom());
      yw_data = 16'($urandom());
      zw_data = 16'($urandom());
      rd1_addr = ($urandom_range(1) == 1) ? wr_addr : 5'($urandom_range(31));
      rd2_addr = 5'($urandom_range(31));
      tick("R8 random");
    end
    idle();
    for (int i = 0; i < 32; i++) begin
      rd1_addr = 5'(i); rd2_addr = 5'(i);
      tick("R4 final sweep");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule